// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

This block is a watchdog that counts on its own free-running tick clock, separate from the system clock, so that it keeps running while the system clock is stopped during sleep. An 8-bit prescaler sits between the watchdog and a general-purpose timer. A single assignment input gives the prescaler to exactly one of them. When the watchdog owns it, the prescaler divides the watchdog's rollover events and stretches the time-out. When the timer owns it, it divides the timer's tick stream. A 3-bit ratio code picks one of eight power-of-two taps.

A time-out ends in one of two ways, depending on the synchronized sleep-mode level. While the device is running, it raises a one-tick reset pulse. While the device is asleep, it raises a one-tick wake-up pulse. In both cases an active-low time-out flag drops. Software-side clear and sleep-entry strobes start in the system clock domain. Each crosses into the watchdog domain through a toggle request/acknowledge handshake. Either strobe restarts the watchdog counter, and it also clears the prescaler only when the watchdog owns the prescaler. The configuration inputs are assumed quasi-static. The single reset input is sampled synchronously by both domains and must be held low for several cycles of each.

Top module: `wdt_psc_top`

## Requirements
- R1: With `psc_to_wdt`=0, the watchdog times out once every 2^CNT_W watchdog ticks (256 by default), whatever `psc_sel` holds.
- R2: With `psc_to_wdt`=1 and `psc_sel`=k (0..7), consecutive time-outs are 2^CNT_W * 2^k ticks apart. Code 0 gives ratio 1.
- R3: With `psc_to_wdt`=0, `tmr_tick_out` pulses one tick after every 2^k-th `tmr_tick_in` tick. With `psc_to_wdt`=1, it repeats every `tmr_tick_in` tick one tick later.
- R4: A clear strobe restarts the watchdog period and clears the prescaler count if `psc_to_wdt`=1. With `psc_to_wdt`=0, the prescaler count (seen through the timer path) is kept. Clears repeated at intervals below the period prevent any time-out.
- R5: A sleep-entry strobe restarts the watchdog period in the same way as a clear.
- R6: A time-out while `sleep_mode`=0 gives `wdt_rst` high for exactly one watchdog tick and leaves `wdt_wake` low.
- R7: A time-out while `sleep_mode`=1 gives a one-tick `wdt_wake` pulse and leaves `wdt_rst` low.
- R8: `to_n` is 1 after reset, goes 0 on any time-out, and returns to 1 only on a clear strobe. A sleep-entry strobe leaves it unchanged.
- R9: While `wdt_en`=0, neither `wdt_rst` nor `wdt_wake` is ever asserted, and `to_n` does not fall.
- R10: A strobe takes effect within 12 watchdog ticks. A burst of strobes on consecutive system cycles is merged and never lost, so the period is counted from no earlier than the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (strobe source domain) |
| rst_n | input | 1 | Active-low reset, sampled synchronously in both domains |
| wdt_clk | input | 1 | Free-running watchdog tick clock |
| clr_cmd | input | 1 | Clear strobe, one system cycle |
| sleep_enter | input | 1 | Sleep-entry strobe, one system cycle |
| sleep_mode | input | 1 | Level: device is asleep |
| wdt_en | input | 1 | Watchdog enable configuration bit |
| psc_to_wdt | input | 1 | 1: prescaler assigned to watchdog, 0: to timer |
| psc_sel | input | 3 | Prescaler ratio code, ratio 2^code |
| tmr_tick_in | input | 1 | Timer tick enable in the watchdog clock domain |
| tmr_tick_out | output | 1 | Prescaled (or bypassed) tick to the timer |
| wdt_rst | output | 1 | Device reset pulse, one watchdog tick |
| wdt_wake | output | 1 | Wake-up pulse, one watchdog tick |
| to_n | output | 1 | Time-out status, active low |

## Verification
The bench builds the block with CNT_W=4, so the base period is 16 ticks and the longest prescaled period is 2048 ticks. This brings all eight ratio codes, with both prescaler assignments, into a short run, and each period can be measured exactly between consecutive time-outs. The other parameters keep their defaults: the full 8-bit prescaler and a two-stage synchronizer. The clear and sleep latency windows are therefore checked against the real crossing depth.

// File: rtl/wdt_psc_pkg.sv
// Shared types for the watchdog with shared prescaler.
// Assumes: nothing; holds only declarations.
package wdt_psc_pkg;

    // Outcome of a time-out decision in the watchdog domain.
    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_RESET = 2'd1,
        OUT_WAKE  = 2'd2
    } wdt_outcome_e;

endpackage

// File: rtl/wdt_strobe_xfer.sv
// Moves a one-cycle strobe from the system domain to the watchdog domain
// using a toggle request with a synchronized acknowledge.
// Assumes: STAGES >= 2; strobes arriving while a transfer is in flight
// are merged into one pending request, which is sent after the acknowledge.
module wdt_strobe_xfer #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic dst_clk,
    input  logic rst_n,
    input  logic strobe,
    output logic dst_pulse
);
    logic              req_t;
    logic              pend;
    logic [STAGES-1:0] req_sync;
    logic              seen;
    logic [STAGES-1:0] ack_sync;
    logic              ack_s;
    logic              busy;

    assign ack_s     = ack_sync[STAGES-1];
    assign busy      = (req_t != ack_s);
    assign dst_pulse = req_sync[STAGES-1] ^ seen;

    // Source side: flip the request when idle, otherwise remember a pending strobe.
    always_ff @(posedge src_clk) begin
        if (!rst_n) begin
            req_t <= 1'b0;
            pend  <= 1'b0;
        end else if ((strobe || pend) && !busy) begin
            req_t <= ~req_t;
            pend  <= 1'b0;
        end else if (strobe) begin
            pend  <= 1'b1;
        end
    end

    // Destination side: synchronize the request toggle and remember the last value seen.
    always_ff @(posedge dst_clk) begin
        if (!rst_n) begin
            req_sync <= '0;
            seen     <= 1'b0;
        end else begin
            req_sync <= {req_sync[STAGES-2:0], req_t};
            seen     <= req_sync[STAGES-1];
        end
    end

    // Source side: bring the acknowledge toggle back.
    always_ff @(posedge src_clk) begin
        if (!rst_n) ack_sync <= '0;
        else        ack_sync <= {ack_sync[STAGES-2:0], seen};
    end

    // R10: a new request is launched only once the previous one is acknowledged.
    p_req_after_ack_r10: assert property (@(posedge src_clk) disable iff (!rst_n)
        !$stable(req_t) |-> $past(req_t == ack_s));

endmodule

// File: rtl/wdt_prescaler.sv
// Shared power-of-two prescaler. Its source is the watchdog rollover event
// when assigned to the watchdog, else the timer tick. An 8-to-1 style tap
// select picks ratio 2^sel. It also drives the registered timer tick output.
// Assumes: PSC_W >= 2^SEL_W - 1; sel and to_wdt are quasi-static.
module wdt_prescaler #(
    parameter int PSC_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             to_wdt,
    input  logic [SEL_W-1:0] sel,
    input  logic             base_evt,
    input  logic             tmr_evt,
    input  logic             restart,
    output logic             psc_hit,
    output logic             tmr_out
);
    logic [PSC_W-1:0] cnt;
    logic [PSC_W-1:0] mask;
    logic             src_evt;

    assign src_evt = to_wdt ? base_evt : tmr_evt;
    assign mask    = (PSC_W'(1) << sel) - PSC_W'(1);
    assign psc_hit = src_evt && (&(cnt | ~mask));

    // Count source events; a restart clears the count only if the watchdog owns it.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (restart && to_wdt)  cnt <= '0;
        else if (src_evt)            cnt <= cnt + PSC_W'(1);
    end

    // Timer output: divided tick when owned by the timer, plain tick otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) tmr_out <= 1'b0;
        else        tmr_out <= to_wdt ? tmr_evt : psc_hit;
    end

    // R4: a restart leaves the count alone while the timer owns the prescaler.
    p_keep_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !to_wdt && !tmr_evt) |=> $stable(cnt));

endmodule

// File: rtl/wdt_core.sv
// Base watchdog counter and time-out outcome logic. It counts every
// watchdog tick while enabled, emits a rollover event, and turns a time-out
// into a reset or a wake-up pulse according to the synchronized sleep level.
// Assumes: CNT_W >= 1, so time-outs are at least two ticks apart.
module wdt_core
    import wdt_psc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic to_wdt,
    input  logic clr_pulse,
    input  logic slp_pulse,
    input  logic sleep_lvl,
    input  logic psc_hit,
    output logic base_evt,
    output logic wdt_rst,
    output logic wdt_wake,
    output logic to_n
);
    logic [CNT_W-1:0] cnt;
    logic [1:0]       slp_sync;
    logic             restart;
    logic             timeout;
    wdt_outcome_e     outc;

    assign restart  = clr_pulse | slp_pulse;
    assign base_evt = en && !restart && (&cnt);
    assign timeout  = to_wdt ? psc_hit : base_evt;

    // Decide what a time-out does in the current power mode.
    always_comb begin
        if (!timeout)          outc = OUT_NONE;
        else if (slp_sync[1])  outc = OUT_WAKE;
        else                   outc = OUT_RESET;
    end

    // Base counter: restart on clear or sleep entry, hold while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else if (en)           cnt <= cnt + CNT_W'(1);
    end

    // Bring the sleep level into the watchdog domain.
    always_ff @(posedge clk) begin
        if (!rst_n) slp_sync <= '0;
        else        slp_sync <= {slp_sync[0], sleep_lvl};
    end

    // Register the one-tick reset and wake-up pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_rst  <= 1'b0;
            wdt_wake <= 1'b0;
        end else begin
            wdt_rst  <= (outc == OUT_RESET);
            wdt_wake <= (outc == OUT_WAKE);
        end
    end

    // Time-out status: set by reset or clear, dropped by a time-out.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_pulse) to_n <= 1'b1;
        else if (timeout)        to_n <= 1'b0;
    end

    // R6: the reset pulse lasts a single tick.
    p_rst_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);
    // R7: reset and wake-up never occur together.
    p_rst_wake_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wdt_rst && wdt_wake));
    // R8: every pulse comes with the status flag low.
    p_flag_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_rst || wdt_wake) |-> !to_n);
    // R9: no pulse follows a cycle with the watchdog disabled.
    p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> !(wdt_rst || wdt_wake));

endmodule

// File: rtl/wdt_psc_top.sv
// Top of the watchdog with shared prescaler. It moves the clear and sleep
// strobes into the watchdog domain and wires the base counter to the prescaler.
// Assumes: rst_n is held low for several cycles of both clocks; the
// configuration inputs change only while no time-out is expected.
module wdt_psc_top #(
    parameter int CNT_W       = 8,
    parameter int PSC_W       = 8,
    parameter int SEL_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdt_clk,
    input  logic             clr_cmd,
    input  logic             sleep_enter,
    input  logic             sleep_mode,
    input  logic             wdt_en,
    input  logic             psc_to_wdt,
    input  logic [SEL_W-1:0] psc_sel,
    input  logic             tmr_tick_in,
    output logic             tmr_tick_out,
    output logic             wdt_rst,
    output logic             wdt_wake,
    output logic             to_n
);
    logic clr_p;
    logic slp_p;
    logic base_evt;
    logic psc_hit;

    wdt_strobe_xfer #(.STAGES(SYNC_STAGES)) u_clr_xfer (
        .src_clk(clk), .dst_clk(wdt_clk), .rst_n(rst_n),
        .strobe(clr_cmd), .dst_pulse(clr_p)
    );

    wdt_strobe_xfer #(.STAGES(SYNC_STAGES)) u_slp_xfer (
        .src_clk(clk), .dst_clk(wdt_clk), .rst_n(rst_n),
        .strobe(sleep_enter), .dst_pulse(slp_p)
    );

    wdt_prescaler #(.PSC_W(PSC_W), .SEL_W(SEL_W)) u_psc (
        .clk(wdt_clk), .rst_n(rst_n), .to_wdt(psc_to_wdt), .sel(psc_sel),
        .base_evt(base_evt), .tmr_evt(tmr_tick_in), .restart(clr_p | slp_p),
        .psc_hit(psc_hit), .tmr_out(tmr_tick_out)
    );

    wdt_core #(.CNT_W(CNT_W)) u_core (
        .clk(wdt_clk), .rst_n(rst_n), .en(wdt_en), .to_wdt(psc_to_wdt),
        .clr_pulse(clr_p), .slp_pulse(slp_p), .sleep_lvl(sleep_mode),
        .psc_hit(psc_hit), .base_evt(base_evt),
        .wdt_rst(wdt_rst), .wdt_wake(wdt_wake), .to_n(to_n)
    );

endmodule

// File: tb/wdt_psc_top_tb_top.sv
// Directed bench for the watchdog with shared prescaler.
module wdt_psc_top_tb_top;
    localparam int CNT_W = 4;
    localparam int BASE  = 1 << CNT_W;
    localparam int MAXW  = BASE * 256 * 2;

    logic       clk = 1'b0;
    logic       wdt_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_cmd = 1'b0;
    logic       sleep_enter = 1'b0;
    logic       sleep_mode = 1'b0;
    logic       wdt_en = 1'b1;
    logic       psc_to_wdt = 1'b0;
    logic [2:0] psc_sel = 3'd0;
    logic       tmr_tick_in = 1'b0;
    logic       tmr_tick_out, wdt_rst, wdt_wake, to_n;

    int checks = 0;
    int fails  = 0;

    always #5  clk = ~clk;
    always #17 wdt_clk = ~wdt_clk;

    wdt_psc_top #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wdt_clk(wdt_clk), .clr_cmd(clr_cmd),
        .sleep_enter(sleep_enter), .sleep_mode(sleep_mode), .wdt_en(wdt_en),
        .psc_to_wdt(psc_to_wdt), .psc_sel(psc_sel), .tmr_tick_in(tmr_tick_in),
        .tmr_tick_out(tmr_tick_out), .wdt_rst(wdt_rst), .wdt_wake(wdt_wake),
        .to_n(to_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg(input logic psa, input int sel);
        @(negedge wdt_clk);
        psc_to_wdt = psa;
        psc_sel    = 3'(sel);
    endtask

    // Count watchdog ticks until a reset or wake pulse is seen.
    task automatic wait_to(output int n, output logic was_rst, output logic was_wake);
        n = 0;
        do begin
            @(negedge wdt_clk);
            n++;
        end while (!(wdt_rst || wdt_wake) && n < MAXW);
        was_rst  = wdt_rst;
        was_wake = wdt_wake;
    endtask

    task automatic strobe_clr();
        @(negedge clk); clr_cmd = 1'b1;
        @(negedge clk); clr_cmd = 1'b0;
    endtask

    task automatic strobe_slp();
        @(negedge clk); sleep_enter = 1'b1;
        @(negedge clk); sleep_enter = 1'b0;
    endtask

    task automatic one_tick(output logic hit);
        @(negedge wdt_clk); tmr_tick_in = 1'b1;
        @(negedge wdt_clk); tmr_tick_in = 1'b0;
        hit = tmr_tick_out;
    endtask

    task automatic t_reset();
        chk(to_n == 1'b1, "R8 reset flag", int'(to_n), 1);
        chk(wdt_rst == 1'b0, "R6 reset idle", int'(wdt_rst), 0);
        chk(wdt_wake == 1'b0, "R7 reset idle", int'(wdt_wake), 0);
    endtask

    task automatic t_periods();
        int n; logic r, w;
        for (int k = 0; k < 8; k++) begin
            cfg(1'b1, k);
            wait_to(n, r, w);
            wait_to(n, r, w);
            chk(n == (BASE << k), $sformatf("R2 period code %0d", k), n, BASE << k);
        end
        cfg(1'b0, 0);
        wait_to(n, r, w);
        wait_to(n, r, w);
        chk(n == BASE, "R1 period code 0", n, BASE);
        cfg(1'b0, 5);
        wait_to(n, r, w);
        wait_to(n, r, w);
        chk(n == BASE, "R1 period code 5", n, BASE);
    endtask

    task automatic t_awake_sleep();
        int n; logic r, w;
        cfg(1'b1, 0);
        wait_to(n, r, w);
        chk(r == 1'b1 && w == 1'b0, "R6 awake gives reset only", int'({r, w}), 2);
        @(negedge wdt_clk);
        chk(wdt_rst == 1'b0, "R6 pulse width", int'(wdt_rst), 0);
        chk(to_n == 1'b0, "R8 flag after time-out", int'(to_n), 0);
        sleep_mode = 1'b1;
        repeat (4) @(negedge wdt_clk);
        wait_to(n, r, w);
        wait_to(n, r, w);
        chk(w == 1'b1 && r == 1'b0, "R7 asleep gives wake only", int'({r, w}), 1);
        chk(n == BASE, "R7 period while asleep", n, BASE);
        @(negedge wdt_clk);
        chk(wdt_wake == 1'b0, "R7 pulse width", int'(wdt_wake), 0);
        sleep_mode = 1'b0;
        repeat (4) @(negedge wdt_clk);
    endtask

    task automatic t_flag();
        int n; logic r, w;
        cfg(1'b1, 3);
        wait_to(n, r, w);
        strobe_slp();
        repeat (12) @(negedge wdt_clk);
        chk(to_n == 1'b0, "R8 sleep strobe keeps flag", int'(to_n), 0);
        strobe_clr();
        repeat (12) @(negedge wdt_clk);
        chk(to_n == 1'b1, "R8 clear sets flag", int'(to_n), 1);
    endtask

    task automatic t_restart();
        int n, pulses; logic r, w;
        cfg(1'b1, 2);
        wait_to(n, r, w);
        repeat (40) @(negedge wdt_clk);
        strobe_clr();
        wait_to(n, r, w);
        chk(n >= 4 * BASE && n <= 4 * BASE + 12, "R4 clear restarts period", n, 4 * BASE);
        repeat (40) @(negedge wdt_clk);
        strobe_slp();
        wait_to(n, r, w);
        chk(n >= 4 * BASE && n <= 4 * BASE + 12, "R5 sleep entry restarts period", n, 4 * BASE);
        repeat (40) @(negedge wdt_clk);
        @(negedge clk); clr_cmd = 1'b1;
        repeat (3) @(negedge clk);
        clr_cmd = 1'b0;
        wait_to(n, r, w);
        chk(n >= 4 * BASE && n <= 4 * BASE + 12, "R10 burst of clears", n, 4 * BASE);
        pulses = 0;
        for (int i = 0; i < 10; i++) begin
            repeat (30) begin
                @(negedge wdt_clk);
                if (wdt_rst || wdt_wake) pulses++;
            end
            strobe_clr();
        end
        chk(pulses == 0, "R4 repeated clears hold off time-out", pulses, 0);
    endtask

    task automatic t_timer_path();
        logic h; int cnt;
        cfg(1'b1, 3);
        cnt = 0;
        for (int i = 0; i < 4; i++) begin
            one_tick(h);
            if (h) cnt++;
        end
        chk(cnt == 4, "R3 bypass when watchdog owns prescaler", cnt, 4);
        cfg(1'b0, 3);
        cnt = 0;
        do begin one_tick(h); cnt++; end while (!h && cnt < 32);
        cnt = 0;
        for (int i = 0; i < 5; i++) begin
            one_tick(h);
            if (h) cnt++;
        end
        strobe_clr();
        repeat (12) @(negedge wdt_clk);
        for (int i = 0; i < 2; i++) begin
            one_tick(h);
            if (h) cnt++;
        end
        chk(cnt == 0, "R4 no early timer tick after clear", cnt, 0);
        one_tick(h);
        chk(h == 1'b1, "R4 timer count kept across clear", int'(h), 1);
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            one_tick(h);
            if (h) cnt++;
        end
        chk(cnt == 1 && h == 1'b1, "R3 one timer tick per 8 inputs", cnt, 1);
    endtask

    task automatic t_disable();
        int pulses;
        cfg(1'b1, 3);
        strobe_clr();
        repeat (4) @(negedge wdt_clk);
        wdt_en = 1'b0;
        pulses = 0;
        repeat (600) begin
            @(negedge wdt_clk);
            if (wdt_rst || wdt_wake) pulses++;
        end
        chk(pulses == 0, "R9 no pulses while disabled", pulses, 0);
        chk(to_n == 1'b1, "R9 flag kept while disabled", int'(to_n), 1);
        wdt_en = 1'b1;
    endtask

    initial begin
        repeat (8) @(negedge wdt_clk);
        rst_n = 1'b1;
        @(negedge wdt_clk);
        t_reset();
        t_periods();
        t_awake_sleep();
        t_flag();
        t_restart();
        t_timer_path();
        t_disable();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule